// File: doc/BRIEF.md
# Dual-Clock Replay FIFO

This block is a first-in first-out buffer with independent write and read clocks that can play its contents back a second time. The write side accepts a word when both of its enables are active and the buffer is not full. The read side delivers words either on request through an output register (standard timing) or by presenting the next word on its own, so that a request only consumes it (fall-through timing). The timing is picked from an input that is captured while the master reset is held.

A level-sensitive mark input pins the position of the next word to be delivered. A retransmit pulse moves the read position back to the pinned word, or to the first word written since the last reset when nothing is pinned. While the mark is held, the pinned words are protected: the full flag is computed against the pinned position, so the writer cannot overwrite data that may still be replayed. A partial reset empties the buffer and clears the output register but keeps the timing choice. A master reset does both and also picks up the timing choice again.

Pointers cross between the clock domains as Gray codes through a parameterised synchronizer chain. The flags are therefore conservative by the synchronizer latency.

Top module: `replay_fifo`

## Requirements
- R1: Words come out on `q_o` in the order they were written. In standard timing, `q_o` takes the new word on the first read clock edge that accepts a read.
- R2: A word is stored only on a write clock edge where `wen_i` and `wcs_i` are both 1 and `full_o` is 0. A write with `wcs_i` at 0 leaves the buffer empty.
- R3: A read is accepted only when `ren_i` and `rcs_i` are both 1. With `rcs_i` at 0, `q_o` holds and no word is consumed.
- R4: In standard timing, a read request while `empty_o` is 1 is ignored, and `q_o` and the read position hold.
- R5: In fall-through timing, the oldest word appears on `q_o` with `rdy_o` at 1 and no request. A request consumes it, and `rdy_o` drops once the buffer runs dry.
- R6: A retransmit with no mark held moves the read position to zero, so the first word written since the last reset is delivered again next.
- R7: Raising `mark_i` pins the next word to be delivered. A retransmit while the mark is held replays from that word.
- R8: In the read cycle right after a retransmit, `empty_o` is 1 in standard timing and `rdy_o` is 0 in fall-through timing. A read requested in the same cycle as a retransmit is dropped.
- R9: While `mark_i` is held, `full_o` rises once the buffer holds DEPTH words counted from the pinned word, and further writes are refused. Lowering `mark_i` releases that space.
- R10: `prst_ni` at 0 clears the pointers and `q_o` to zero, and leaves the selected timing unchanged.
- R11: The timing is sampled from `cfg_fwft_i` (0 for standard, 1 for fall-through) on read clock edges while `mrst_ni` is 0. After reset the buffer is empty, `full_o` is 0 and `rdy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| mrst_ni | input | 1 | Master reset, active low, asynchronous |
| prst_ni | input | 1 | Partial reset, active low, asynchronous |
| cfg_fwft_i | input | 1 | Timing select captured during master reset (1 = fall-through) |
| wen_i | input | 1 | Write enable |
| wcs_i | input | 1 | Write chip select, second write enable |
| din_i | input | DW | Write data |
| full_o | output | 1 | Buffer full, write clock domain |
| ren_i | input | 1 | Read enable |
| rcs_i | input | 1 | Read chip select |
| mark_i | input | 1 | Mark level; rising pins the read position |
| rt_i | input | 1 | Retransmit request, read clock domain |
| q_o | output | DW | Read data register |
| empty_o | output | 1 | Empty flag (in fall-through timing, the inverse of `rdy_o`) |
| rdy_o | output | 1 | Output word valid in fall-through timing |

## Verification
The case that needs the most care is a retransmit that lands on the same read edge as an accepted read request. The retransmit must win: the read position rewinds and the requested word is not consumed. The bench raises `ren_i` and `rt_i` together on one edge. It then lets the scoreboard judge the replayed stream against the expected queue, which was rebuilt from the write history at the rewind target, and checks the flag state in the following cycle. A second case is held-mark protection meeting a write attempt while full: the bench fills up against the pinned word, tries one more write, and confirms from the word count read back after the mark is released that the refused word never appeared.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;

   typedef enum logic {
      RD_STD  = 1'b0,
      RD_FWFT = 1'b1
   } rd_mode_e;

   function automatic logic [31:0] to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] from_gray(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/replay_fifo_sync.sv
module replay_fifo_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= '0;
         else        stg <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= '0;
         else        stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/replay_fifo_mem.sv
module replay_fifo_mem #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];

endmodule

// File: rtl/replay_fifo_wr.sv
module replay_fifo_wr
   import replay_fifo_pkg::*;
#(
   parameter int AW   = 4,
   parameter int SYNC = 2
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          wen_i,
   input  logic          wcs_i,
   input  logic [AW:0]   lim_gray_i,
   output logic          we_o,
   output logic [AW-1:0] waddr_o,
   output logic [AW:0]   wptr_o,
   output logic [AW:0]   wgray_o,
   output logic          full_o
);

   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [PW-1:0] lim_sync;
   logic [PW-1:0] lim_bin;
   logic [PW-1:0] wptr;
   logic [PW-1:0] wnxt;
   logic [PW-1:0] wgray;
   logic          full_q;
   logic          we;

   replay_fifo_sync #(.W(PW), .STAGES(SYNC)) u_lim_sync (
      .clk   (wclk),
      .rst_n (rst_n),
      .d     (lim_gray_i),
      .q     (lim_sync)
   );

   always_comb begin
      lim_bin = PW'(from_gray(32'(lim_sync)));
      we      = wen_i & wcs_i & ~full_q;
      wnxt    = wptr + PW'(we);
   end

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wptr   <= '0;
         wgray  <= '0;
         full_q <= 1'b0;
      end else begin
         wptr   <= wnxt;
         wgray  <= PW'(to_gray(32'(wnxt)));
         full_q <= ((wnxt - lim_bin) == PW'(DEPTH));
      end
   end

   assign we_o    = we;
   assign waddr_o = wptr[AW-1:0];
   assign wptr_o  = wptr;
   assign wgray_o = wgray;
   assign full_o  = full_q;

endmodule

// File: rtl/replay_fifo_rd.sv
module replay_fifo_rd
   import replay_fifo_pkg::*;
#(
   parameter int DW   = 8,
   parameter int AW   = 4,
   parameter int SYNC = 2
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          mrst_ni,
   input  logic          cfg_fwft_i,
   input  logic          ren_i,
   input  logic          rcs_i,
   input  logic          mark_i,
   input  logic          rt_i,
   input  logic [AW:0]   wgray_i,
   input  logic [DW-1:0] rdata_i,
   output logic [AW-1:0] raddr_o,
   output logic [DW-1:0] q_o,
   output logic          empty_o,
   output logic          rdy_o,
   output logic [AW:0]   lim_gray_o,
   output logic [AW:0]   rptr_o,
   output logic [AW:0]   mptr_o,
   output logic          mvalid_o,
   output logic          fwft_o
);

   localparam int PW = AW + 1;

   rd_mode_e      mode_q;
   logic [PW-1:0] wsync;
   logic [PW-1:0] wbin;
   logic [PW-1:0] rptr;
   logic [PW-1:0] rnxt;
   logic [PW-1:0] mptr;
   logic [PW-1:0] tgt;
   logic [PW-1:0] dptr;
   logic [PW-1:0] lim;
   logic [PW-1:0] lim_gray;
   logic [DW-1:0] q_q;
   logic          mvalid;
   logic          empty_q;
   logic          ordy;
   logic          rd_req;
   logic          has_data;
   logic          adv;
   logic          fwft;

   replay_fifo_sync #(.W(PW), .STAGES(SYNC)) u_wptr_sync (
      .clk   (rclk),
      .rst_n (rst_n),
      .d     (wgray_i),
      .q     (wsync)
   );

   // timing choice survives partial reset: only the master reset reloads it
   always_ff @(posedge rclk) begin
      if (!mrst_ni) mode_q <= rd_mode_e'(cfg_fwft_i);
   end

   assign fwft = (mode_q == RD_FWFT);

   always_comb begin
      wbin     = PW'(from_gray(32'(wsync)));
      rd_req   = ren_i & rcs_i;
      has_data = (wbin != rptr);
      tgt      = mvalid ? mptr : '0;
      if (fwft) adv = !rt_i && has_data && (!ordy || rd_req);
      else      adv = !rt_i && rd_req && !empty_q;
      rnxt     = rt_i ? tgt : (rptr + PW'(adv));
      // next word owed to the user; in fall-through it already sits on q
      dptr     = (fwft && ordy) ? (rptr - PW'(1)) : rptr;
      lim      = mvalid ? mptr : rptr;
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rptr     <= '0;
         q_q      <= '0;
         empty_q  <= 1'b1;
         ordy     <= 1'b0;
         mvalid   <= 1'b0;
         mptr     <= '0;
         lim_gray <= '0;
      end else begin
         rptr    <= rnxt;
         empty_q <= rt_i | (rnxt == wbin);
         if (adv) q_q <= rdata_i;
         if (rt_i)        ordy <= 1'b0;
         else if (adv)    ordy <= 1'b1;
         else if (rd_req) ordy <= 1'b0;
         if (!mark_i) begin
            mvalid <= 1'b0;
         end else if (!mvalid) begin
            mvalid <= 1'b1;
            mptr   <= dptr;
         end
         lim_gray <= PW'(to_gray(32'(lim)));
      end
   end

   assign raddr_o    = rptr[AW-1:0];
   assign q_o        = q_q;
   assign empty_o    = fwft ? ~ordy : empty_q;
   assign rdy_o      = fwft & ordy;
   assign lim_gray_o = lim_gray;
   assign rptr_o     = rptr;
   assign mptr_o     = mptr;
   assign mvalid_o   = mvalid;
   assign fwft_o     = fwft;

endmodule

// File: rtl/replay_fifo.sv
module replay_fifo #(
   parameter int DW   = 8,
   parameter int AW   = 4,
   parameter int SYNC = 2
) (
   input  logic          wclk_i,
   input  logic          rclk_i,
   input  logic          mrst_ni,
   input  logic          prst_ni,
   input  logic          cfg_fwft_i,
   input  logic          wen_i,
   input  logic          wcs_i,
   input  logic [DW-1:0] din_i,
   output logic          full_o,
   input  logic          ren_i,
   input  logic          rcs_i,
   input  logic          mark_i,
   input  logic          rt_i,
   output logic [DW-1:0] q_o,
   output logic          empty_o,
   output logic          rdy_o
);

   localparam int PW = AW + 1;

   initial begin
      if (DW < 1)   $fatal(1, "replay_fifo: DW must be at least 1");
      if (AW < 2)   $fatal(1, "replay_fifo: AW must be at least 2");
      if (AW > 12)  $fatal(1, "replay_fifo: AW above 12 makes too large a register file");
      if (SYNC < 2) $fatal(1, "replay_fifo: SYNC needs two or more stages");
   end

   logic          rst_all_n;
   logic          we_w;
   logic [AW-1:0] waddr_w;
   logic [AW-1:0] raddr_w;
   logic [DW-1:0] rdata_w;
   logic [PW-1:0] wptr_w;
   logic [PW-1:0] wgray_w;
   logic [PW-1:0] lim_gray_w;
   logic [PW-1:0] rptr_w;
   logic [PW-1:0] mptr_w;
   logic          mvalid_w;
   logic          fwft_w;

   assign rst_all_n = mrst_ni & prst_ni;

   replay_fifo_mem #(.DW(DW), .AW(AW)) u_mem (
      .wclk  (wclk_i),
      .we    (we_w),
      .waddr (waddr_w),
      .wdata (din_i),
      .raddr (raddr_w),
      .rdata (rdata_w)
   );

   replay_fifo_wr #(.AW(AW), .SYNC(SYNC)) u_wr (
      .wclk       (wclk_i),
      .rst_n      (rst_all_n),
      .wen_i      (wen_i),
      .wcs_i      (wcs_i),
      .lim_gray_i (lim_gray_w),
      .we_o       (we_w),
      .waddr_o    (waddr_w),
      .wptr_o     (wptr_w),
      .wgray_o    (wgray_w),
      .full_o     (full_o)
   );

   replay_fifo_rd #(.DW(DW), .AW(AW), .SYNC(SYNC)) u_rd (
      .rclk       (rclk_i),
      .rst_n      (rst_all_n),
      .mrst_ni    (mrst_ni),
      .cfg_fwft_i (cfg_fwft_i),
      .ren_i      (ren_i),
      .rcs_i      (rcs_i),
      .mark_i     (mark_i),
      .rt_i       (rt_i),
      .wgray_i    (wgray_w),
      .rdata_i    (rdata_w),
      .raddr_o    (raddr_w),
      .q_o        (q_o),
      .empty_o    (empty_o),
      .rdy_o      (rdy_o),
      .lim_gray_o (lim_gray_w),
      .rptr_o     (rptr_w),
      .mptr_o     (mptr_w),
      .mvalid_o   (mvalid_w),
      .fwft_o     (fwft_w)
   );

endmodule

// File: rtl/replay_fifo_chk.sv
module replay_fifo_chk #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input logic          wclk_i,
   input logic          rclk_i,
   input logic          mrst_ni,
   input logic          prst_ni,
   input logic          wen_i,
   input logic          wcs_i,
   input logic          full_o,
   input logic          rcs_i,
   input logic          rt_i,
   input logic [DW-1:0] q_o,
   input logic          empty_o,
   input logic          rdy_o,
   input logic [AW:0]   wptr,
   input logic [AW:0]   rptr,
   input logic [AW:0]   mptr,
   input logic          mvalid,
   input logic          fwft
);

   logic rst_all;
   assign rst_all = mrst_ni & prst_ni;

   // R2
   full_block_chk: assert property (@(posedge wclk_i) disable iff (!rst_all)
      (full_o && wen_i && wcs_i) |=> $stable(wptr));

   // R2
   wcs_gate_chk: assert property (@(posedge wclk_i) disable iff (!rst_all)
      !wcs_i |=> $stable(wptr));

   // R3
   rcs_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_all)
      (!fwft && !rcs_i && !rt_i) |=> $stable(q_o));

   // R4
   empty_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_all)
      (!fwft && empty_o && !rt_i) |=> ($stable(q_o) && $stable(rptr)));

   // R6
   rewind_zero_chk: assert property (@(posedge rclk_i) disable iff (!rst_all)
      (rt_i && !mvalid) |=> (rptr == '0));

   // R7
   rewind_mark_chk: assert property (@(posedge rclk_i) disable iff (!rst_all)
      (rt_i && mvalid) |=> (rptr == $past(mptr)));

   // R8
   rewind_flag_chk: assert property (@(posedge rclk_i) disable iff (!rst_all)
      rt_i |=> (fwft ? !rdy_o : empty_o));

   // R10
   mode_keep_chk: assert property (@(posedge rclk_i) disable iff (!mrst_ni)
      !prst_ni |=> (fwft == $past(fwft)));

   // R10
   always @(posedge rclk_i) begin
      if (mrst_ni === 1'b1 && prst_ni === 1'b0) begin
         prst_clear_chk: assert (q_o == '0 && rptr == '0);
      end
   end

endmodule

bind replay_fifo replay_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
   .wclk_i  (wclk_i),
   .rclk_i  (rclk_i),
   .mrst_ni (mrst_ni),
   .prst_ni (prst_ni),
   .wen_i   (wen_i),
   .wcs_i   (wcs_i),
   .full_o  (full_o),
   .rcs_i   (rcs_i),
   .rt_i    (rt_i),
   .q_o     (q_o),
   .empty_o (empty_o),
   .rdy_o   (rdy_o),
   .wptr    (wptr_w),
   .rptr    (rptr_w),
   .mptr    (mptr_w),
   .mvalid  (mvalid_w),
   .fwft    (fwft_w)
);

// File: tb/replay_fifo_bench.sv
module replay_fifo_bench;

   localparam int DW = 8;
   localparam int AW = 4;

   logic          wclk = 1'b0;
   logic          rclk = 1'b0;
   logic          mrst_n = 1'b0;
   logic          prst_n = 1'b1;
   logic          cfg_fwft = 1'b0;
   logic          wen = 1'b0;
   logic          wcs = 1'b1;
   logic [DW-1:0] din = '0;
   logic          full;
   logic          ren = 1'b0;
   logic          rcs = 1'b1;
   logic          mark = 1'b0;
   logic          rt = 1'b0;
   logic [DW-1:0] q;
   logic          empty;
   logic          rdy;

   always #10 rclk = ~rclk;
   initial begin
      #7;
      forever #10 wclk = ~wclk;
   end

   replay_fifo #(.DW(DW), .AW(AW), .SYNC(2)) u_replay_fifo (
      .wclk_i     (wclk),
      .rclk_i     (rclk),
      .mrst_ni    (mrst_n),
      .prst_ni    (prst_n),
      .cfg_fwft_i (cfg_fwft),
      .wen_i      (wen),
      .wcs_i      (wcs),
      .din_i      (din),
      .full_o     (full),
      .ren_i      (ren),
      .rcs_i      (rcs),
      .mark_i     (mark),
      .rt_i       (rt),
      .q_o        (q),
      .empty_o    (empty),
      .rdy_o      (rdy)
   );

   int            checks = 0;
   int            fails = 0;
   bit            done = 1'b0;
   bit            mode_fwft = 1'b0;
   bit            pend = 1'b0;
   int            nextval = 1;
   string         cur_req = "R1";
   logic [DW-1:0] hist[$];
   logic [DW-1:0] expq[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic compare_word();
      logic [DW-1:0] e;
      checks++;
      if (expq.size() == 0) begin
         fails++;
         $display("FAIL %s: unexpected word, actual %0d expected none", cur_req, q);
      end else begin
         e = expq.pop_front();
         if (q !== e) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", cur_req, q, e);
         end
      end
   endtask

   // monitor: judges every accepted read against the scoreboard queue
   always @(negedge rclk) begin
      if (mrst_n !== 1'b1 || prst_n !== 1'b1) begin
         pend = 1'b0;
      end else begin
         if (pend) compare_word();
         pend = 1'b0;
         if (!mode_fwft) pend = ren && rcs && !empty && !rt;
         else if (ren && rcs && rdy && !rt) compare_word();
      end
   end

   task automatic wr_words(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge wclk); #2;
         wen = 1'b1;
         wcs = 1'b1;
         din = DW'(nextval);
         hist.push_back(DW'(nextval));
         expq.push_back(DW'(nextval));
         nextval++;
      end
      @(posedge wclk); #2;
      wen = 1'b0;
   endtask

   task automatic rd_words(input int n);
      @(posedge rclk); #2;
      ren = 1'b1;
      rcs = 1'b1;
      repeat (n) @(posedge rclk);
      #2;
      ren = 1'b0;
   endtask

   task automatic settle();
      repeat (8) @(posedge rclk);
      @(negedge rclk);
   endtask

   task automatic retx(input bit with_read, input int from_idx);
      @(posedge rclk); #2;
      rt  = 1'b1;
      ren = with_read;
      rcs = 1'b1;
      expq.delete();
      for (int i = from_idx; i < hist.size(); i++) expq.push_back(hist[i]);
      @(posedge rclk); #2;
      rt  = 1'b0;
      ren = 1'b0;
      @(negedge rclk);
   endtask

   task automatic master_reset(input bit fw);
      mrst_n    = 1'b0;
      prst_n    = 1'b1;
      cfg_fwft  = fw;
      mode_fwft = fw;
      hist.delete();
      expq.delete();
      repeat (4) @(posedge rclk);
      #2;
      mrst_n = 1'b1;
      repeat (2) @(posedge rclk);
      @(negedge rclk);
   endtask

   task automatic partial_reset();
      @(posedge rclk); #2;
      prst_n = 1'b0;
      cfg_fwft = ~cfg_fwft;
      hist.delete();
      expq.delete();
      repeat (3) @(posedge rclk);
      @(negedge rclk);
      chk(q == '0, "R10", q, 0);
      chk(empty == 1'b1 && rdy == 1'b0, "R10", {empty, rdy}, 2);
      @(posedge rclk); #2;
      prst_n = 1'b1;
      settle();
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1: watchdog expired, actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      // ---------------- standard timing ----------------
      master_reset(1'b0);
      chk(empty == 1'b1, "R11", empty, 1);
      chk(full == 1'b0, "R11", full, 0);
      chk(rdy == 1'b0, "R11", rdy, 0);
      chk(q == '0, "R11", q, 0);

      // R2: chip select low blocks the write
      @(posedge wclk); #2;
      wen = 1'b1; wcs = 1'b0; din = 8'hEE;
      @(posedge wclk); #2;
      wen = 1'b0; wcs = 1'b1;
      settle();
      chk(empty == 1'b1, "R2", empty, 1);

      // R4: read while empty is ignored
      rd_words(2);
      settle();
      chk(q == '0, "R4", q, 0);

      cur_req = "R1";
      wr_words(5);
      settle();
      chk(empty == 1'b0, "R1", empty, 0);

      // R3: read chip select low holds everything
      @(posedge rclk); #2;
      ren = 1'b1; rcs = 1'b0;
      repeat (3) @(posedge rclk);
      #2;
      ren = 1'b0; rcs = 1'b1;
      @(negedge rclk);
      chk(q == '0, "R3", q, 0);
      chk(empty == 1'b0, "R3", empty, 0);

      rd_words(3);
      settle();

      // R6 + R8: rewind to zero with a read request on the same edge
      cur_req = "R6";
      retx(1'b1, 0);
      chk(empty == 1'b1, "R8", empty, 1);
      settle();
      rd_words(5);
      settle();
      chk(empty == 1'b1, "R6", empty, 1);
      chk(expq.size() == 0, "R6", expq.size(), 0);

      // R7: mark and replay from the marked word
      cur_req = "R7";
      wr_words(4);
      settle();
      rd_words(1);
      settle();
      @(posedge rclk); #2;
      mark = 1'b1;
      @(posedge rclk); #2;
      rd_words(2);
      settle();
      retx(1'b0, 6);
      chk(empty == 1'b1, "R8", empty, 1);
      settle();
      rd_words(3);
      settle();
      chk(expq.size() == 0, "R7", expq.size(), 0);

      // R9: held mark bounds the writer
      cur_req = "R9";
      wr_words(13);
      @(negedge wclk);
      chk(full == 1'b1, "R9", full, 1);
      @(posedge wclk); #2;
      wen = 1'b1; din = 8'hAA;
      @(posedge wclk); #2;
      wen = 1'b0;
      @(negedge wclk);
      chk(full == 1'b1, "R9", full, 1);
      @(posedge rclk); #2;
      mark = 1'b0;
      settle();
      @(negedge wclk);
      chk(full == 1'b0, "R9", full, 0);
      rd_words(13);
      settle();
      chk(empty == 1'b1, "R9", empty, 1);
      chk(expq.size() == 0, "R9", expq.size(), 0);

      // R10: partial reset in standard timing
      cur_req = "R10";
      wr_words(2);
      settle();
      rd_words(1);
      settle();
      partial_reset();
      wr_words(1);
      settle();
      chk(q == '0, "R10", q, 0);
      chk(empty == 1'b0, "R10", empty, 0);
      rd_words(1);
      settle();
      chk(expq.size() == 0, "R10", expq.size(), 0);

      // ---------------- fall-through timing ----------------
      master_reset(1'b1);
      chk(rdy == 1'b0, "R11", rdy, 0);
      chk(empty == 1'b1, "R11", empty, 1);
      cur_req = "R5";
      wr_words(3);
      settle();
      chk(rdy == 1'b1, "R5", rdy, 1);
      chk(q == hist[0], "R5", q, hist[0]);
      rd_words(3);
      settle();
      chk(rdy == 1'b0, "R5", rdy, 0);

      cur_req = "R6";
      retx(1'b0, 0);
      chk(rdy == 1'b0, "R8", rdy, 0);
      settle();
      chk(rdy == 1'b1, "R6", rdy, 1);
      chk(q == hist[0], "R6", q, hist[0]);
      rd_words(3);
      settle();
      chk(expq.size() == 0, "R6", expq.size(), 0);

      cur_req = "R10";
      partial_reset();
      wr_words(1);
      settle();
      chk(rdy == 1'b1, "R10", rdy, 1);
      chk(q == hist[0], "R10", q, hist[0]);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule